// File: doc/BRIEF.md
# Packed SIMD Lane Arithmetic Unit

This unit treats two 64-bit words as vectors of equal-width lanes and combines them lane by lane. The first operand `op_a` acts as the destination. The unit computes `op_a op op_b` and returns it as the new destination value. It can add, subtract (A minus B), test for equality or test for signed greater-than. Compares write a full lane of ones or a full lane of zeros. They do not produce flags.

The lanes can be eight bytes, four 16-bit halfwords or two 32-bit words. Addition and subtraction offer three overflow policies: wrap-around, signed clamping and unsigned clamping. Clamping is only defined for byte and halfword lanes. When the command fields form a combination the unit does not define, it raises `illegal_op` and passes `op_a` through unchanged.

The result is registered. A command accepted with `in_valid` appears on `result` in the next cycle, with `out_valid` set. A new command can be issued every cycle.

Top module: `simd_lane_unit`

## Requirements
- R1: A command presented with `in_valid` high at a rising edge appears on `result` and `illegal_op` after that edge, with `out_valid` high. A cycle without `in_valid` is followed by `out_valid` low. Synchronous active-low reset clears `out_valid`, `result` and `illegal_op`.
- R2: `lane_sel` picks the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. Lane i occupies bits [i*n +: n], with lane 0 least significant. No carry, borrow or compare result crosses a lane boundary.
- R3: `op_sel` 0 adds and 1 subtracts (A minus B). With `arith_mode` 0 the result wraps modulo 2^n, for all three lane widths.
- R4: With `arith_mode` 1, addition and subtraction treat lanes as two's-complement values and clamp to [-2^(n-1), 2^(n-1)-1].
- R5: With `arith_mode` 2, addition and subtraction treat lanes as unsigned values and clamp to [0, 2^n-1].
- R6: `op_sel` 2 sets a lane to all ones when the A and B lanes are equal, and to all zeros otherwise. For compares, `arith_mode` has no effect.
- R7: `op_sel` 3 sets a lane to all ones when the A lane is greater than the B lane as a signed value, and to all zeros otherwise.
- R8: The following combinations raise `illegal_op` and return `op_a` unchanged as the result:
  - `lane_sel` 3, for any operation;
  - `arith_mode` 3 with add or subtract;
  - `arith_mode` 1 or 2 with 32-bit lanes for add or subtract.

  Every other combination returns `illegal_op` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Command present this cycle |
| op_a | input | 64 | Destination / first operand |
| op_b | input | 64 | Source / second operand |
| op_sel | input | 2 | 0 add, 1 subtract, 2 equal, 3 signed greater-than |
| lane_sel | input | 2 | 0 8-bit, 1 16-bit, 2 32-bit, 3 reserved |
| arith_mode | input | 2 | 0 wrap, 1 signed clamp, 2 unsigned clamp, 3 reserved |
| out_valid | output | 1 | Result registered from the previous command |
| result | output | 64 | New destination value |
| illegal_op | output | 1 | Command combination not defined |

## Verification
Directed patterns target specific boundaries:
- Values one step beyond each clamp boundary separate the three overflow policies.
- Lanes holding all ones, followed by an increment, show whether a carry leaks into the next lane, and so test the lane width decode.
- Equal operands, and operands that differ only in the sign bit, separate equality from signed and unsigned ordering.
- A byte compare example with mixed equal, greater and smaller lanes checks the per-lane mask placement.

A long run of random operands over every field combination, reserved codes included, is then compared against an independent per-lane model. This run also exercises the pass-through of A on undefined commands.

// File: rtl/simd_lane_pkg.sv
// Package simd_lane_pkg
// Shared field encodings for the packed lane unit.
// Assumes the command fields are two bits wide each.
package simd_lane_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_EQ  = 2'd2,
        OP_GT  = 2'd3
    } simd_op_e;

    typedef enum logic [1:0] {
        LN_8    = 2'd0,
        LN_16   = 2'd1,
        LN_32   = 2'd2,
        LN_RSVD = 2'd3
    } simd_lane_e;

    typedef enum logic [1:0] {
        MD_WRAP = 2'd0,
        MD_SSAT = 2'd1,
        MD_USAT = 2'd2,
        MD_RSVD = 2'd3
    } simd_mode_e;

    localparam int NUM_WIDTHS = 3;
    localparam int BASE_LANE_W = 8;

endpackage

// File: rtl/simd_lane_alu.sv
// Module simd_lane_alu
// One lane of the unit: add, subtract, equality or signed greater-than
// on LANE_W-bit values, with wrap, signed clamp or unsigned clamp.
// Assumes the caller has already screened illegal combinations.
module simd_lane_alu
    import simd_lane_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a_i,
    input  logic [LANE_W-1:0] b_i,
    input  simd_op_e          op_i,
    input  simd_mode_e        mode_i,
    output logic [LANE_W-1:0] y_o
);

    localparam int MSB = LANE_W - 1;
    localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};

    logic [LANE_W:0] sum_w;
    logic [LANE_W:0] dif_w;
    logic            add_sov;
    logic            sub_sov;

    // Raw sums with carry and borrow, plus signed overflow detection.
    always_comb begin
        sum_w   = {1'b0, a_i} + {1'b0, b_i};
        dif_w   = {1'b0, a_i} - {1'b0, b_i};
        add_sov = (a_i[MSB] == b_i[MSB]) && (sum_w[MSB] != a_i[MSB]);
        sub_sov = (a_i[MSB] != b_i[MSB]) && (dif_w[MSB] != a_i[MSB]);
    end

    // Select the lane result from the operation and overflow policy.
    always_comb begin
        y_o = '0;
        unique case (op_i)
            OP_ADD: begin
                if (mode_i == MD_SSAT && add_sov)
                    y_o = a_i[MSB] ? SMIN : SMAX;
                else if (mode_i == MD_USAT && sum_w[LANE_W])
                    y_o = UMAX;
                else
                    y_o = sum_w[LANE_W-1:0];
            end
            OP_SUB: begin
                if (mode_i == MD_SSAT && sub_sov)
                    y_o = a_i[MSB] ? SMIN : SMAX;
                else if (mode_i == MD_USAT && dif_w[LANE_W])
                    y_o = '0;
                else
                    y_o = dif_w[LANE_W-1:0];
            end
            OP_EQ:   y_o = {LANE_W{a_i == b_i}};
            OP_GT:   y_o = {LANE_W{$signed(a_i) > $signed(b_i)}};
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_lane_slice.sv
// Module simd_lane_slice
// Splits a DATA_W word into DATA_W/LANE_W lanes and runs one lane ALU
// per lane; lane i sits at bits [i*LANE_W +: LANE_W].
// Assumes DATA_W is a multiple of LANE_W.
module simd_lane_slice
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  simd_op_e          op_i,
    input  simd_mode_e        mode_i,
    output logic [DATA_W-1:0] y_o
);

    localparam int NUM_LANES = DATA_W / LANE_W;

    // One independent lane per position; no signal crosses lanes.
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        simd_lane_alu #(
            .LANE_W (LANE_W)
        ) u_lane (
            .a_i    (a_i[i*LANE_W +: LANE_W]),
            .b_i    (b_i[i*LANE_W +: LANE_W]),
            .op_i   (op_i),
            .mode_i (mode_i),
            .y_o    (y_o[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/simd_cmd_check.sv
// Module simd_cmd_check
// Flags operation / lane width / mode combinations the unit does not
// define. Clamping modes are accepted only up to MAX_SAT_LANE.
// Compares ignore the mode field entirely.
module simd_cmd_check
    import simd_lane_pkg::*;
#(
    parameter simd_lane_e MAX_SAT_LANE = LN_16
) (
    input  simd_op_e   op_i,
    input  simd_lane_e lane_i,
    input  simd_mode_e mode_i,
    output logic       bad_o
);

    logic is_arith;
    logic sat_mode;

    // Decode which fields matter and test each restriction.
    always_comb begin
        is_arith = (op_i == OP_ADD) || (op_i == OP_SUB);
        sat_mode = (mode_i == MD_SSAT) || (mode_i == MD_USAT);
        bad_o    = (lane_i == LN_RSVD)
                || (is_arith && mode_i == MD_RSVD)
                || (is_arith && sat_mode && (lane_i > MAX_SAT_LANE));
    end

endmodule

// File: rtl/simd_lane_unit.sv
// Module simd_lane_unit
// Registered packed-lane arithmetic: result = A op B per lane, one cycle
// after in_valid. Illegal commands return A and set illegal_op.
// Assumes DATA_W is a multiple of the widest lane (32 bits).
module simd_lane_unit
    import simd_lane_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        lane_sel,
    input  logic [1:0]        arith_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    simd_op_e          op_e;
    simd_lane_e        lane_e;
    simd_mode_e        mode_e;
    logic              cmd_bad;
    logic [DATA_W-1:0] width_res [NUM_WIDTHS];
    logic [DATA_W-1:0] next_res;

    // Cast the raw command fields to their encodings.
    always_comb begin
        op_e   = simd_op_e'(op_sel);
        lane_e = simd_lane_e'(lane_sel);
        mode_e = simd_mode_e'(arith_mode);
    end

    simd_cmd_check #(
        .MAX_SAT_LANE (LN_16)
    ) u_check (
        .op_i   (op_e),
        .lane_i (lane_e),
        .mode_i (mode_e),
        .bad_o  (cmd_bad)
    );

    // One lane slice per supported lane width.
    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        simd_lane_slice #(
            .DATA_W (DATA_W),
            .LANE_W (BASE_LANE_W << g)
        ) u_slice (
            .a_i    (op_a),
            .b_i    (op_b),
            .op_i   (op_e),
            .mode_i (mode_e),
            .y_o    (width_res[g])
        );
    end

    // Choose the slice matching the lane width, or pass A on bad commands.
    always_comb begin
        next_res = op_a;
        if (!cmd_bad) begin
            unique case (lane_e)
                LN_8:    next_res = width_res[0];
                LN_16:   next_res = width_res[1];
                LN_32:   next_res = width_res[2];
                default: next_res = op_a;
            endcase
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            result     <= '0;
            illegal_op <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result     <= next_res;
                illegal_op <= cmd_bad;
            end
        end
    end

endmodule

// File: rtl/simd_lane_unit_chk.sv
// Module simd_lane_unit_chk
// Property checker for simd_lane_unit, attached by bind below.
// Assumes the default 64-bit data width.
module simd_lane_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [1:0]  op_sel,
    input logic [1:0]  lane_sel,
    input logic [1:0]  arith_mode,
    input logic        out_valid,
    input logic [63:0] result,
    input logic        illegal_op
);

    // R1: an accepted command yields a valid result next cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: an idle cycle yields no result
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: reserved lane width returns A and flags it
    a_r8_rsvd_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_sel == 2'd3) |=> (illegal_op && result == $past(op_a)));

    // R8: clamping on 32-bit lanes is rejected
    a_r8_sat_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel < 2'd2 && lane_sel == 2'd2 &&
         (arith_mode == 2'd1 || arith_mode == 2'd2))
        |=> (illegal_op && result == $past(op_a)));

    // R6: equal operands give an all-ones mask
    a_r6_eq_self: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd2 && lane_sel != 2'd3 && op_a == op_b)
        |=> (!illegal_op && result == '1));

    // R7: a lane is never greater than itself
    a_r7_gt_self: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd3 && lane_sel != 2'd3 && op_a == op_b)
        |=> (!illegal_op && result == '0));

    // R5: unsigned clamped byte add never falls below A in lane 0
    a_r5_usat_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0 && lane_sel == 2'd0 && arith_mode == 2'd2)
        |=> (result[7:0] >= $past(op_a[7:0])));

endmodule

bind simd_lane_unit simd_lane_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_a       (op_a),
    .op_b       (op_b),
    .op_sel     (op_sel),
    .lane_sel   (lane_sel),
    .arith_mode (arith_mode),
    .out_valid  (out_valid),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/sim_simd_lane_unit.sv
// Scoreboard bench for simd_lane_unit: a driver task pushes expected
// results computed from the requirements; a monitor pops and compares.
module sim_simd_lane_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [63:0] exp_res;
        logic        exp_bad;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  lane_sel = '0;
    logic [1:0]  arith_mode = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int    n_checks = 0;
    int    n_fails  = 0;
    item_t sb_q[$];

    simd_lane_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_a       (op_a),
        .op_b       (op_b),
        .op_sel     (op_sel),
        .lane_sel   (lane_sel),
        .arith_mode (arith_mode),
        .out_valid  (out_valid),
        .result     (result),
        .illegal_op (illegal_op)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Per-lane model built from R2-R8; returns {illegal, result}.
    function automatic logic [64:0] ref_model(input logic [63:0] a, input logic [63:0] b,
                                              input logic [1:0] op, input logic [1:0] ln,
                                              input logic [1:0] md);
        logic [63:0] r;
        logic [63:0] mask;
        longint ua, ub, sa, sb, v, half, full;
        int n;
        bit bad;
        bad = (ln == 2'd3) || (op < 2'd2 && (md == 2'd3 || (md != 2'd0 && ln == 2'd2)));
        if (bad) return {1'b1, a};
        n    = 8 << ln;
        mask = (64'd1 << n) - 64'd1;
        half = longint'(1) << (n - 1);
        full = longint'(1) << n;
        r    = '0;
        for (int i = 0; i < 64 / n; i++) begin
            ua = longint'((a >> (i * n)) & mask);
            ub = longint'((b >> (i * n)) & mask);
            sa = (ua >= half) ? ua - full : ua;
            sb = (ub >= half) ? ub - full : ub;
            case (op)
                2'd0:    v = (md == 2'd1) ? sa + sb : ua + ub;
                2'd1:    v = (md == 2'd1) ? sa - sb : ua - ub;
                2'd2:    v = (ua == ub) ? -1 : 0;
                default: v = (sa > sb) ? -1 : 0;
            endcase
            if (op < 2'd2 && md == 2'd1) begin
                if (v > half - 1) v = half - 1;
                if (v < -half)    v = -half;
            end
            if (op < 2'd2 && md == 2'd2) begin
                if (v > full - 1) v = full - 1;
                if (v < 0)        v = 0;
            end
            r = r | ((64'(v) & mask) << (i * n));
        end
        return {1'b0, r};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: present one command and push its expected outcome.
    task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op,
                         input logic [1:0] ln, input logic [1:0] md, input string tag);
        logic [64:0] m;
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; lane_sel = ln; arith_mode = md;
        in_valid = 1'b1;
        m = ref_model(a, b, op, ln, md);
        it.exp_res = m[63:0];
        it.exp_bad = m[64];
        it.tag     = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each registered result against the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected out_valid", result, '0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                check(result == it.exp_res, it.tag, result, it.exp_res);
                check(illegal_op == it.exp_bad, {it.tag, " illegal_op"},
                      64'(illegal_op), 64'(it.exp_bad));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", sb_q.size());
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && result == '0 && illegal_op == 1'b0, "R1 reset",
              result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3 wrap on every width; R2 no carry across lanes
        drive(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 2'd0, 2'd0, "R3 add8 wrap");
        drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd0, 2'd1, 2'd0, "R2 add16 lane edge");
        drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd0, 2'd2, 2'd0, "R2 add32 lane edge");
        drive(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd1, 2'd2, 2'd0, "R3 sub32 wrap");
        drive(64'h1000_2000_3000_4000, 64'h0001_0002_0003_0004, 2'd1, 2'd1, 2'd0, "R3 sub16 A-B");
        // R4 signed clamp
        drive(64'h0000_0000_0000_807F, 64'h0000_0000_0000_0101, 2'd0, 2'd0, 2'd1, "R4 add8 clamp");
        drive(64'h0000_0000_0000_807F, 64'h0000_0000_0000_01FF, 2'd1, 2'd0, 2'd1, "R4 sub8 clamp");
        drive(64'h0000_0000_7FFF_8000, 64'h0000_0000_0001_FFFF, 2'd0, 2'd1, 2'd1, "R4 add16 clamp");
        // R5 unsigned clamp
        drive(64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0101, 2'd0, 2'd0, 2'd2, "R5 add8 ceiling");
        drive(64'h0000_0000_0000_0005, 64'h0000_0000_0000_0306, 2'd1, 2'd0, 2'd2, "R5 sub8 floor");
        drive(64'h0000_0000_FFF0_0010, 64'h0000_0000_0020_0020, 2'd1, 2'd1, 2'd2, "R5 sub16 floor");
        // R6/R7 byte example and sign-bit ordering
        drive(64'h0000_0000_0000_6F33, 64'h0000_0001_0000_5F33, 2'd2, 2'd0, 2'd0, "R6 eq8 example");
        drive(64'h0000_0000_0000_6F33, 64'h0000_0001_0000_5F33, 2'd3, 2'd0, 2'd0, "R7 gt8 example");
        drive(64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, 2'd3, 2'd2, 2'd0, "R7 gt32 signed");
        drive(64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_0000, 2'd2, 2'd1, 2'd3, "R6 eq16 mode ignored");
        // R8 illegal combinations
        drive(64'hDEAD_BEEF_0123_4567, 64'h1111_1111_1111_1111, 2'd0, 2'd2, 2'd1, "R8 ssat32");
        drive(64'hCAFE_F00D_89AB_CDEF, 64'h2222_2222_2222_2222, 2'd1, 2'd2, 2'd2, "R8 usat32");
        drive(64'h0123_4567_89AB_CDEF, 64'h3333_3333_3333_3333, 2'd2, 2'd3, 2'd0, "R8 lane rsvd");
        drive(64'h7654_3210_FEDC_BA98, 64'h4444_4444_4444_4444, 2'd0, 2'd0, 2'd3, "R8 mode rsvd");
        idle();
        repeat (2) @(negedge clk);
        #1;
        // R1: no result after idle cycles
        check(out_valid == 1'b0, "R1 idle", 64'(out_valid), '0);

        // Random sweep over every field combination
        for (int k = 0; k < 400; k++) begin
            logic [63:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = (k % 7 == 0) ? ra : {$urandom, $urandom};
            drive(ra, rb, 2'($urandom), 2'($urandom), 2'($urandom), "R2 random sweep");
            if (k % 50 == 49) idle();
        end
        idle();
        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R1 queue drained", 64'(sb_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule